// File: doc/BRIEF.md
# Burst Packet Size Divisor Search

This block chooses the burst length that a DMA engine uses to move one audio period between memory and a port FIFO. It is given the period length in words, the largest FIFO fill threshold the port accepts, and whether the port runs in threshold-driven DMA mode. It returns a packet size, the threshold to program, and a synchronisation mode. The synchronisation mode is one of three: one word per request (element), the whole period as one request (frame), or fixed packets (packet).

When the period does not fit under the threshold, the block looks for a divisor of the period. The search starts at the rounded-up quotient of period over threshold and counts upward. The first candidate that divides the period exactly gives the packet size, which is the period divided by that candidate. The remainder test for each candidate runs on a shared restoring divider that produces one bit per cycle, so no full divider sits in a single cycle. A start/done handshake frames each request.

Top module: `pkt_div_search`

## Requirements
- R1: After reset, busy, done and error are 0, and packetSize, threshold and syncMode are 0.
- R2: When threshMode is 0, the result is syncMode 0 (element), threshold 1, packetSize 0 and error 0, whatever the other inputs are.
- R3: When threshMode is 1, maxThresh is non-zero and periodWords is at most maxThresh, the result is syncMode 1 (frame), packetSize 0, threshold equal to periodWords and error 0.
- R4: When threshMode is 1 and periodWords exceeds maxThresh, the block takes d as the smallest integer that is at least ceil(periodWords/maxThresh), lies below periodWords and divides periodWords. The result is syncMode 2 (packet), packetSize equal to periodWords/d, threshold equal to packetSize and error 0.
- R5: When no such d exists in R4, which always happens for maxThresh of 1, error is 1 and packetSize, threshold and syncMode are 0.
- R6: When threshMode is 1 and maxThresh is 0, error is 1 with the same zero outputs as R5, and no division is started.
- R7: Inputs are sampled on the clock edge where start is high and busy is low. A start pulse or an input change while busy has no effect on the result in progress.
- R8: done is a one-cycle pulse. It rises one cycle after the result outputs take their new values, and busy is low whenever done is high. For element, frame and the R6 error case, done is high in the third cycle after the cycle in which start was high.
- R9: The result outputs hold their values until the next request completes. Input changes without start leave them unchanged.
- R10: Every division inside the search produces a remainder smaller than its divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| threshMode | input | 1 | 1 when the port uses threshold-driven DMA |
| periodWords | input | 16 | Period length in words |
| maxThresh | input | 16 | Largest FIFO threshold allowed |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | No legal packet size was found |
| syncMode | output | 2 | 0 element, 1 frame, 2 packet |
| packetSize | output | 16 | Words per burst in packet mode, else 0 |
| threshold | output | 16 | FIFO threshold to program |

## Verification
Periods at or below the threshold, including the equal case, separate frame mode from the search. Periods whose ceiling quotient already divides them exactly (1000 over 128, 300 over 128, 130 over 128) confirm the starting point of the search. Periods that need several increments (1024 over 100, 77 over 10) confirm that the search steps upward and stops at the first divisor rather than the largest packet. A prime period, a threshold of one and a zero threshold drive the error path, the element mode is tried with a period that would otherwise search, and a mid-search restart with different inputs checks that the sampled values are the ones kept.

// File: rtl/pkt_div_pkg.sv
package pkt_div_pkg;

  typedef enum logic [1:0] {
    SYNC_ELEMENT = 2'd0,
    SYNC_FRAME   = 2'd1,
    SYNC_PACKET  = 2'd2
  } syncModeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic divLoad;
    logic divByCand;
    logic candInit;
    logic candInc;
    logic resElement;
    logic resFrame;
    logic resPacket;
    logic resError;
  } dpCmdT;

  // Status from datapath to control
  typedef struct packed {
    logic thrMode;
    logic maxZero;
    logic fitsWhole;
    logic divFin;
    logic remZero;
    logic candAtPeriod;
  } dpStatT;

endpackage

// File: rtl/pkt_div_restoring.sv
module pkt_div_restoring #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic         fin,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remQ, quoQ, divQ;
  logic [CW-1:0] cntQ;
  logic          activeQ, finQ;
  logic [W:0]    shifted, trial;
  logic          fits;

  always_comb begin
    shifted = {remQ, quoQ[W-1]};
    trial   = shifted - {1'b0, divQ};
    fits    = ~trial[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remQ    <= '0;
      quoQ    <= '0;
      divQ    <= '0;
      cntQ    <= '0;
      activeQ <= 1'b0;
      finQ    <= 1'b0;
    end else begin
      finQ <= 1'b0;
      if (load) begin
        remQ    <= '0;
        quoQ    <= dividendIn;
        divQ    <= divisorIn;
        cntQ    <= CW'(W);
        activeQ <= 1'b1;
      end else if (activeQ) begin
        remQ <= fits ? trial[W-1:0] : shifted[W-1:0];
        quoQ <= {quoQ[W-2:0], fits};
        cntQ <= cntQ - 1'b1;
        if (cntQ == CW'(1)) begin
          activeQ <= 1'b0;
          finQ    <= 1'b1;
        end
      end
    end
  end

  assign fin       = finQ;
  assign quotient  = quoQ;
  assign remainder = remQ;

  assert_divisor_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> divisorIn != '0);

  assert_rem_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> remainder < divQ);

endmodule

// File: rtl/pkt_div_datapath.sv
module pkt_div_datapath
  import pkt_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dpCmdT        cmd,
  input  logic         busyIn,
  input  logic         doneIn,
  input  logic         threshModeIn,
  input  logic [W-1:0] periodIn,
  input  logic [W-1:0] maxIn,
  output dpStatT       stat,
  output logic         errorOut,
  output logic [1:0]   syncOut,
  output logic [W-1:0] pktOut,
  output logic [W-1:0] thrOut
);
  logic [W-1:0] periodQ, maxQ, candQ, pktQ, thrQ;
  logic         modeQ, errQ;
  syncModeT     syncQ;

  logic         divFin;
  logic [W-1:0] divQuot, divRem, divisorSel;

  assign divisorSel = cmd.divByCand ? candQ : maxQ;

  pkt_div_restoring #(.W(W)) uDiv (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd.divLoad),
    .dividendIn (periodQ),
    .divisorIn  (divisorSel),
    .fin        (divFin),
    .quotient   (divQuot),
    .remainder  (divRem)
  );

  // sampled request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodQ <= '0;
      maxQ    <= '0;
      modeQ   <= 1'b0;
    end else if (cmd.capture) begin
      periodQ <= periodIn;
      maxQ    <= maxIn;
      modeQ   <= threshModeIn;
    end
  end

  // divisor candidate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      candQ <= '0;
    end else if (cmd.candInit) begin
      candQ <= divQuot + {{(W-1){1'b0}}, |divRem};
    end else if (cmd.candInc) begin
      candQ <= candQ + 1'b1;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pktQ  <= '0;
      thrQ  <= '0;
      syncQ <= SYNC_ELEMENT;
      errQ  <= 1'b0;
    end else if (cmd.resElement) begin
      pktQ  <= '0;
      thrQ  <= W'(1);
      syncQ <= SYNC_ELEMENT;
      errQ  <= 1'b0;
    end else if (cmd.resFrame) begin
      pktQ  <= '0;
      thrQ  <= periodQ;
      syncQ <= SYNC_FRAME;
      errQ  <= 1'b0;
    end else if (cmd.resPacket) begin
      pktQ  <= divQuot;
      thrQ  <= divQuot;
      syncQ <= SYNC_PACKET;
      errQ  <= 1'b0;
    end else if (cmd.resError) begin
      pktQ  <= '0;
      thrQ  <= '0;
      syncQ <= SYNC_ELEMENT;
      errQ  <= 1'b1;
    end
  end

  always_comb begin
    stat.thrMode      = modeQ;
    stat.maxZero      = (maxQ == '0);
    stat.fitsWhole    = (periodQ <= maxQ);
    stat.divFin       = divFin;
    stat.remZero      = (divRem == '0);
    stat.candAtPeriod = (candQ >= periodQ);
  end

  assign errorOut = errQ;
  assign syncOut  = syncQ;
  assign pktOut   = pktQ;
  assign thrOut   = thrQ;

  assert_elem_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIn && !modeQ) |-> (syncQ == SYNC_ELEMENT && thrQ == W'(1) && !errQ));

  assert_frame_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIn && syncQ == SYNC_FRAME) |-> (thrQ == periodQ && periodQ <= maxQ));

  assert_pkt_divides_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIn && syncQ == SYNC_PACKET) |->
      (pktQ != '0 && pktQ <= maxQ && (periodQ % pktQ) == '0 && pktQ > W'(1)));

  assert_zero_max_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIn && modeQ && maxQ == '0) |-> errQ);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busyIn |=> ($stable(periodQ) && $stable(maxQ) && $stable(modeQ)));

endmodule

// File: rtl/pkt_div_ctrl.sv
module pkt_div_ctrl
  import pkt_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  dpStatT stat,
  output dpCmdT  cmd,
  output logic   busy,
  output logic   done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_DIVQ, ST_TEST, ST_DIVR, ST_REPORT
  } stateT;

  stateT stateQ, stateD;
  logic  doneQ;

  always_comb begin
    cmd    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          cmd.capture = 1'b1;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!stat.thrMode) begin
          cmd.resElement = 1'b1;
          stateD         = ST_REPORT;
        end else if (stat.maxZero) begin
          cmd.resError = 1'b1;
          stateD       = ST_REPORT;
        end else if (stat.fitsWhole) begin
          cmd.resFrame = 1'b1;
          stateD       = ST_REPORT;
        end else begin
          cmd.divLoad = 1'b1;
          stateD      = ST_DIVQ;
        end
      end
      ST_DIVQ: begin
        if (stat.divFin) begin
          cmd.candInit = 1'b1;
          stateD       = ST_TEST;
        end
      end
      ST_TEST: begin
        if (stat.candAtPeriod) begin
          cmd.resError = 1'b1;
          stateD       = ST_REPORT;
        end else begin
          cmd.divLoad   = 1'b1;
          cmd.divByCand = 1'b1;
          stateD        = ST_DIVR;
        end
      end
      ST_DIVR: begin
        cmd.divByCand = 1'b1;
        if (stat.divFin) begin
          if (stat.remZero) begin
            cmd.resPacket = 1'b1;
            stateD        = ST_REPORT;
          end else begin
            cmd.candInc = 1'b1;
            stateD      = ST_TEST;
          end
        end
      end
      ST_REPORT: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == ST_REPORT);
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_one_result_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.resElement, cmd.resFrame, cmd.resPacket, cmd.resError}));

endmodule

// File: rtl/pkt_div_search.sv
module pkt_div_search
  import pkt_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         threshMode,
  input  logic [W-1:0] periodWords,
  input  logic [W-1:0] maxThresh,
  output logic         busy,
  output logic         done,
  output logic         error,
  output logic [1:0]   syncMode,
  output logic [W-1:0] packetSize,
  output logic [W-1:0] threshold
);
  dpCmdT  cmd;
  dpStatT stat;

  pkt_div_ctrl uCtrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stat  (stat),
    .cmd   (cmd),
    .busy  (busy),
    .done  (done)
  );

  pkt_div_datapath #(.W(W)) uDp (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .busyIn       (busy),
    .doneIn       (done),
    .threshModeIn (threshMode),
    .periodIn     (periodWords),
    .maxIn        (maxThresh),
    .stat         (stat),
    .errorOut     (error),
    .syncOut      (syncMode),
    .pktOut       (packetSize),
    .thrOut       (threshold)
  );

endmodule

// File: tb/pkt_div_search_test.sv
module pkt_div_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        threshMode = 1'b0;
  logic [15:0] periodWords = '0;
  logic [15:0] maxThresh = '0;
  logic        busy, done, error;
  logic [1:0]  syncMode;
  logic [15:0] packetSize, threshold;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  pkt_div_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .threshMode(threshMode),
    .periodWords(periodWords), .maxThresh(maxThresh), .busy(busy), .done(done),
    .error(error), .syncMode(syncMode), .packetSize(packetSize), .threshold(threshold)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int p, input int m, input bit tm,
                                output int sm, output int pk, output int th, output bit er);
    int d;
    sm = 0; pk = 0; th = 0; er = 1'b0;
    if (!tm) th = 1;
    else if (m == 0) er = 1'b1;
    else if (p <= m) begin sm = 1; th = p; end
    else begin
      d = (p + m - 1) / m;
      while (d < p && (p % d) != 0) d++;
      if (d >= p) er = 1'b1;
      else begin sm = 2; pk = p / d; th = pk; end
    end
  endfunction

  task automatic waitDone(input string req, output int lat);
    lat = 1;
    while (!done && lat < 40000) begin @(negedge clk); lat++; end
    check(done, {req, " watchdog"}, done, 1);
  endtask

  task automatic compare(input string req, input int p, input int m, input bit tm);
    int sm, pk, th; bit er;
    model(p, m, tm, sm, pk, th, er);
    check(syncMode == 2'(sm), {req, " syncMode"}, syncMode, sm);
    check(packetSize == 16'(pk), {req, " packetSize"}, packetSize, pk);
    check(threshold == 16'(th), {req, " threshold"}, threshold, th);
    check(error == er, {req, " error"}, error, er);
  endtask

  task automatic runCase(input string req, input int p, input int m, input bit tm,
                         input int expLat);
    int lat;
    @(negedge clk);
    periodWords = 16'(p); maxThresh = 16'(m); threshMode = tm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, {req, " busy"}, busy, 1);
    waitDone(req, lat);
    if (expLat > 0) check(lat == expLat, "R8 latency", lat, expLat);
    check(!busy, "R8 idle at done", busy, 0);
    compare(req, p, m, tm);
    @(negedge clk);
    check(!done, "R8 done pulse", done, 0);
  endtask

  task automatic testReset();
    check(!busy && !done, "R1 busy/done", {busy, done}, 0);
    check(!error, "R1 error", error, 0);
    check(syncMode == 2'd0, "R1 syncMode", syncMode, 0);
    check(packetSize == 0 && threshold == 0, "R1 sizes", packetSize + threshold, 0);
  endtask

  task automatic testIgnoreBusy();
    int lat;
    @(negedge clk);
    periodWords = 16'd1024; maxThresh = 16'd100; threshMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    periodWords = 16'd64; maxThresh = 16'd128; threshMode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R7", lat);
    compare("R7 start while busy", 1024, 100, 1'b1);
    @(negedge clk);
    check(!busy, "R7 no second request", busy, 0);
  endtask

  task automatic testHold();
    logic [15:0] pk, th;
    logic [1:0]  sm;
    pk = packetSize; th = threshold; sm = syncMode;
    periodWords = 16'd9; maxThresh = 16'd2; threshMode = 1'b1;
    repeat (12) @(negedge clk);
    check(packetSize == pk, "R9 packetSize held", packetSize, pk);
    check(threshold == th, "R9 threshold held", threshold, th);
    check(syncMode == sm && !busy, "R9 syncMode held", syncMode, sm);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    runCase("R2 element", 1000, 10, 1'b0, 3);
    runCase("R3 frame below", 64, 128, 1'b1, 3);
    runCase("R3 frame equal", 128, 128, 1'b1, 3);
    runCase("R4 exact start", 1000, 128, 1'b1, 0);
    runCase("R4 stepping", 1024, 100, 1'b1, 0);
    runCase("R4 ceil three", 300, 128, 1'b1, 0);
    runCase("R4 near fit", 130, 128, 1'b1, 0);
    runCase("R4 odd composite", 77, 10, 1'b1, 0);
    testHold();
    runCase("R5 prime", 127, 100, 1'b1, 0);
    runCase("R5 unit threshold", 50, 1, 1'b1, 0);
    runCase("R6 zero threshold", 40, 0, 1'b1, 3);
    testIgnoreBusy();
    runCase("R10 long search", 1009, 3, 1'b1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule